// File: doc/BRIEF.md
# Context-Switch Microprogram Sequencer

This block runs a small stored microprogram that saves or restores the register context of a graphics engine. Software first fills a 256-word program memory through a write port. A start pulse then begins execution at address 0. Each 32-bit word is decoded in one cycle. The instruction set has a conditional branch, a wait on a flag, a flag write, a length-register load, a register-range transfer request and a small set of fixed command words. Execution continues until an end command halts the sequencer and raises `done`, or until an illegal word halts it and raises `error`.

Decisions are driven by a 128-entry flag file indexed by a 7-bit number, where the index equals word*32+bit. Most flags are plain storage that the program writes. A few flags are tied to the outside world:
- Flag 0 gives the swap direction (0 load, 1 save).
- Flag 96 is the live engine-busy input.
- Flags 5, 6, 100 and 101 are sticky latches for the user-save, user-load, auto-save and auto-load requests.
- Flag 104 always reads as one.

A register-range transfer is handed to the data mover as a request carrying a start register index and a count, held until acknowledged. A command word is shown as a one-cycle strobe with its code.

Top module: `ctxseq_top`

## Requirements
- R1: After reset the sequencer is idle: `running`, `done`, `error`, `xferValid` and `cmdStrobe` are 0 and `lenReg` is 0.
- R2: A word with bits 31:20 equal to 0x002 loads bits 19:0 into `lenReg` and moves to the next address.
- R3: A word with bits 31:20 equal to 0x001 raises `xferValid` with `xferReg` = bits 13:0 and `xferCount` = bits 19:14. All three hold unchanged until `xferAck`, and execution moves to the next address only after the acknowledge.
- R4: A word with bits 31:20 equal to 0x004 jumps to the address in bits 15:8 when the flag indexed by bits 6:0 equals bit 7, and otherwise falls through. Flag 104 always reads 1.
- R5: A word with bits 31:20 equal to 0x005 stalls at its address until the flag indexed by bits 6:0 equals bit 7. While it stalls, no transfer or command is issued.
- R6: A word with bits 31:20 equal to 0x007 writes bit 7 into the flag indexed by bits 6:0, and a later branch reads the new value. Writes to flags 96 and 104 have no effect.
- R7: Request inputs set sticky latches that read as flags 5 (userSaveReq), 6 (userLoadReq), 100 (autoSaveReq) and 101 (autoLoadReq). A flag write of 0 to one of these flags clears its latch, and a write of 1 leaves it unchanged. Flag 96 reads the live `engBusy` input.
- R8: Command words 0x00600007, 0x00600009 and 0x0060000A each give a single `cmdStrobe` cycle with `cmdCode` equal to bits 3:0 (7, 9, A) and continue. Word 0x0060000E strobes with code E, halts, and raises `done`.
- R9: A word whose bits 31:20 hold any value other than those above, or a command word outside the four listed, raises `error` and halts without a strobe. `done` and `error` are never both set.
- R10: `start` while idle or halted restarts at address 0 and clears `done` and `error`. `start` while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution at address 0 |
| progWe | input | 1 | Program memory write enable |
| progAddr | input | 8 | Program memory write address |
| progData | input | 32 | Program memory write data |
| engBusy | input | 1 | Engine busy status, read live as flag 96 |
| userSaveReq | input | 1 | User save request, latched into flag 5 |
| userLoadReq | input | 1 | User load request, latched into flag 6 |
| autoSaveReq | input | 1 | Automatic save request, latched into flag 100 |
| autoLoadReq | input | 1 | Automatic load request, latched into flag 101 |
| xferValid | output | 1 | Register-range transfer request |
| xferReg | output | 14 | First register index of the transfer |
| xferCount | output | 6 | Number of registers to transfer |
| xferAck | input | 1 | Transfer acknowledge |
| cmdStrobe | output | 1 | One-cycle command strobe |
| cmdCode | output | 4 | Low nibble of the command word |
| lenReg | output | 20 | Length register |
| running | output | 1 | Sequencer is executing |
| done | output | 1 | Halted on the end command |
| error | output | 1 | Halted on an illegal word |

## Verification
The checker assumes that program memory is not written while the sequencer is running. It also assumes that `xferAck` is asserted only while `xferValid` is high. The bench loads programs only between runs, and its acknowledge responder answers only a pending request, after a programmable delay of zero to three cycles. Request pulses are applied only while the sequencer is idle, so each run sees a fixed latch state. The bench then sweeps flag value against branch polarity for storage, constant, live and latched flags, and its expected command sequence follows directly from that comparison.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_XFER,
    S_HALT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pcClear;
    logic pcStep;
    logic pcJump;
    logic lenLoad;
    logic flagWrite;
  } seqCtl_t;

  localparam logic [11:0] OP_XFER = 12'h001;
  localparam logic [11:0] OP_LEN  = 12'h002;
  localparam logic [11:0] OP_BRA  = 12'h004;
  localparam logic [11:0] OP_WAIT = 12'h005;
  localparam logic [11:0] OP_CMD  = 12'h006;
  localparam logic [11:0] OP_SET  = 12'h007;

  localparam logic [3:0] CMD_TO_SWAP  = 4'h7;
  localparam logic [3:0] CMD_TO_CUR   = 4'h9;
  localparam logic [3:0] CMD_CTX_PTR  = 4'hA;
  localparam logic [3:0] CMD_END      = 4'hE;

  localparam int FLAG_N        = 128;
  localparam int FLAG_USR_SAVE = 5;
  localparam int FLAG_USR_LOAD = 6;
  localparam int FLAG_BUSY     = 96;
  localparam int FLAG_AUT_SAVE = 100;
  localparam int FLAG_AUT_LOAD = 101;
  localparam int FLAG_ONE      = 104;

endpackage

// File: rtl/ctxseq_dpath.sv
module ctxseq_dpath
  import ctxseq_pkg::*;
#(
  parameter int PROG_DEPTH = 256,
  parameter int LEN_W      = 20,
  localparam int ADDR_W    = $clog2(PROG_DEPTH),
  localparam int SEL_W     = $clog2(FLAG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [31:0]       progData,
  input  seqCtl_t           ctl,
  input  logic              engBusy,
  input  logic              userSaveReq,
  input  logic              userLoadReq,
  input  logic              autoSaveReq,
  input  logic              autoLoadReq,
  output logic [31:0]       instr,
  output logic              flagBit,
  output logic [LEN_W-1:0]  lenReg
);

  logic [31:0]       progMem [PROG_DEPTH];
  logic [ADDR_W-1:0] pc;
  logic [FLAG_N-1:0] progFlags;
  logic [FLAG_N-1:0] flagView;
  logic              usrSavePend, usrLoadPend, autSavePend, autLoadPend;
  logic [SEL_W-1:0]  flagSel;
  logic              flagVal;
  logic              isSpecial;
  logic              clrHit;

  always_ff @(posedge clk) begin
    if (progWe) progMem[progAddr] <= progData;
  end

  assign instr   = progMem[pc];
  assign flagSel = instr[SEL_W-1:0];
  assign flagVal = instr[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pc <= '0;
    else if (ctl.pcClear)   pc <= '0;
    else if (ctl.pcJump)    pc <= instr[8 +: ADDR_W];
    else if (ctl.pcStep)    pc <= pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lenReg <= '0;
    else if (ctl.lenLoad) lenReg <= instr[LEN_W-1:0];
  end

  // flags driven from outside are never overwritten by the program
  assign isSpecial = (flagSel == SEL_W'(FLAG_USR_SAVE)) || (flagSel == SEL_W'(FLAG_USR_LOAD)) ||
                     (flagSel == SEL_W'(FLAG_AUT_SAVE)) || (flagSel == SEL_W'(FLAG_AUT_LOAD)) ||
                     (flagSel == SEL_W'(FLAG_BUSY))     || (flagSel == SEL_W'(FLAG_ONE));
  assign clrHit = ctl.flagWrite && !flagVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) progFlags <= '0;
    else if (ctl.flagWrite && !isSpecial) progFlags[flagSel] <= flagVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usrSavePend <= 1'b0;
      usrLoadPend <= 1'b0;
      autSavePend <= 1'b0;
      autLoadPend <= 1'b0;
    end else begin
      usrSavePend <= (usrSavePend && !(clrHit && flagSel == SEL_W'(FLAG_USR_SAVE))) || userSaveReq;
      usrLoadPend <= (usrLoadPend && !(clrHit && flagSel == SEL_W'(FLAG_USR_LOAD))) || userLoadReq;
      autSavePend <= (autSavePend && !(clrHit && flagSel == SEL_W'(FLAG_AUT_SAVE))) || autoSaveReq;
      autLoadPend <= (autLoadPend && !(clrHit && flagSel == SEL_W'(FLAG_AUT_LOAD))) || autoLoadReq;
    end
  end

  always_comb begin
    flagView                = progFlags;
    flagView[FLAG_USR_SAVE] = usrSavePend;
    flagView[FLAG_USR_LOAD] = usrLoadPend;
    flagView[FLAG_BUSY]     = engBusy;
    flagView[FLAG_AUT_SAVE] = autSavePend;
    flagView[FLAG_AUT_LOAD] = autLoadPend;
    flagView[FLAG_ONE]      = 1'b1;
  end

  assign flagBit = flagView[flagSel];

endmodule

// File: rtl/ctxseq_ctrl.sv
module ctxseq_ctrl
  import ctxseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] instr,
  input  logic        flagBit,
  input  logic        xferAck,
  output seqCtl_t     ctl,
  output logic        xferValid,
  output logic        cmdStrobe,
  output logic        running,
  output logic        done,
  output logic        error
);

  seqState_t   state, nextState;
  logic        setDone, setErr, clrStatus;
  logic        cmdKnown;
  logic        condMet;
  logic [11:0] opField;

  assign opField  = instr[31:20];
  assign condMet  = (flagBit == instr[7]);
  assign cmdKnown = (instr[19:4] == '0) &&
                    (instr[3:0] == CMD_TO_SWAP || instr[3:0] == CMD_TO_CUR ||
                     instr[3:0] == CMD_CTX_PTR || instr[3:0] == CMD_END);

  always_comb begin
    ctl       = '0;
    nextState = state;
    cmdStrobe = 1'b0;
    setDone   = 1'b0;
    setErr    = 1'b0;
    clrStatus = 1'b0;
    unique case (state)
      S_IDLE, S_HALT: begin
        if (start) begin
          ctl.pcClear = 1'b1;
          clrStatus   = 1'b1;
          nextState   = S_RUN;
        end
      end
      S_RUN: begin
        unique case (opField)
          OP_XFER: nextState = S_XFER;
          OP_LEN: begin
            ctl.lenLoad = 1'b1;
            ctl.pcStep  = 1'b1;
          end
          OP_BRA: begin
            ctl.pcJump = condMet;
            ctl.pcStep = !condMet;
          end
          OP_WAIT: ctl.pcStep = condMet;
          OP_SET: begin
            ctl.flagWrite = 1'b1;
            ctl.pcStep    = 1'b1;
          end
          OP_CMD: begin
            if (cmdKnown) begin
              cmdStrobe = 1'b1;
              if (instr[3:0] == CMD_END) begin
                setDone   = 1'b1;
                nextState = S_HALT;
              end else begin
                ctl.pcStep = 1'b1;
              end
            end else begin
              setErr    = 1'b1;
              nextState = S_HALT;
            end
          end
          default: begin
            setErr    = 1'b1;
            nextState = S_HALT;
          end
        endcase
      end
      S_XFER: begin
        if (xferAck) begin
          ctl.pcStep = 1'b1;
          nextState  = S_RUN;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      if (clrStatus) begin
        done  <= 1'b0;
        error <= 1'b0;
      end else begin
        if (setDone) done  <= 1'b1;
        if (setErr)  error <= 1'b1;
      end
    end
  end

  assign xferValid = (state == S_XFER);
  assign running   = (state == S_RUN) || (state == S_XFER);

endmodule

// File: rtl/ctxseq_top.sv
module ctxseq_top
  import ctxseq_pkg::*;
#(
  parameter int PROG_DEPTH = 256,
  parameter int LEN_W      = 20,
  localparam int ADDR_W    = $clog2(PROG_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [31:0]       progData,
  input  logic              engBusy,
  input  logic              userSaveReq,
  input  logic              userLoadReq,
  input  logic              autoSaveReq,
  input  logic              autoLoadReq,
  output logic              xferValid,
  output logic [13:0]       xferReg,
  output logic [5:0]        xferCount,
  input  logic              xferAck,
  output logic              cmdStrobe,
  output logic [3:0]        cmdCode,
  output logic [LEN_W-1:0]  lenReg,
  output logic              running,
  output logic              done,
  output logic              error
);

  seqCtl_t     ctl;
  logic [31:0] instr;
  logic        flagBit;

  ctxseq_dpath #(.PROG_DEPTH(PROG_DEPTH), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN),
    .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .ctl(ctl), .engBusy(engBusy),
    .userSaveReq(userSaveReq), .userLoadReq(userLoadReq),
    .autoSaveReq(autoSaveReq), .autoLoadReq(autoLoadReq),
    .instr(instr), .flagBit(flagBit), .lenReg(lenReg)
  );

  ctxseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .instr(instr), .flagBit(flagBit), .xferAck(xferAck),
    .ctl(ctl), .xferValid(xferValid), .cmdStrobe(cmdStrobe),
    .running(running), .done(done), .error(error)
  );

  assign xferReg   = instr[13:0];
  assign xferCount = instr[19:14];
  assign cmdCode   = instr[3:0];

endmodule

// File: rtl/ctxseq_chk.sv
module ctxseq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        xferValid,
  input logic [13:0] xferReg,
  input logic [5:0]  xferCount,
  input logic        xferAck,
  input logic        cmdStrobe,
  input logic [3:0]  cmdCode,
  input logic        running,
  input logic        done,
  input logic        error
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!xferValid && !cmdStrobe));

  p_xfer_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !xferAck) |=> (xferValid && $stable(xferReg) && $stable(xferCount)));

  p_end_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && cmdCode == 4'hE) |=> (done && !running));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!cmdStrobe && !xferValid && !done));

  p_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !running) |=> (running && !done && !error));

endmodule

bind ctxseq_top ctxseq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start),
  .xferValid(xferValid), .xferReg(xferReg), .xferCount(xferCount), .xferAck(xferAck),
  .cmdStrobe(cmdStrobe), .cmdCode(cmdCode),
  .running(running), .done(done), .error(error)
);

// File: tb/sim_ctxseq_top.sv
module sim_ctxseq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rstN = 1'b0, start = 1'b0, progWe = 1'b0;
  logic [7:0]  progAddr = '0;
  logic [31:0] progData = '0;
  logic        engBusy = 1'b0, userSaveReq = 1'b0, userLoadReq = 1'b0;
  logic        autoSaveReq = 1'b0, autoLoadReq = 1'b0, xferAck = 1'b0;
  logic        xferValid, cmdStrobe, running, done, error;
  logic [13:0] xferReg;
  logic [5:0]  xferCount;
  logic [3:0]  cmdCode;
  logic [19:0] lenReg;

  ctxseq_top u0 (.*);

  int checks = 0, fails = 0;
  int cmdLog [16];
  int cmdN = 0;
  int xN = 0, xRegLog = 0, xCntLog = 0, ackDelay = 0, waitCnt = 0;

  always @(negedge clk) begin
    if (cmdStrobe && cmdN < 16) begin
      cmdLog[cmdN] = int'(cmdCode);
      cmdN++;
    end
    if (xferValid && !xferAck) begin
      if (waitCnt >= ackDelay) begin
        xferAck = 1'b1;
        xN++;
        xRegLog = int'(xferReg);
        xCntLog = int'(xferCount);
        waitCnt = 0;
      end else waitCnt++;
    end else xferAck = 1'b0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic logic [31:0] fXfer(int r, int c); return 32'h0010_0000 | (32'(c) << 14) | 32'(r); endfunction
  function automatic logic [31:0] fLen(int v);         return 32'h0020_0000 | (32'(v) & 32'hFFFFF); endfunction
  function automatic logic [31:0] fBra(int f, int p, int t); return 32'h0040_0000 | (32'(t) << 8) | (32'(p) << 7) | 32'(f); endfunction
  function automatic logic [31:0] fWait(int f, int p); return 32'h0050_0000 | (32'(p) << 7) | 32'(f); endfunction
  function automatic logic [31:0] fSet(int f, int v);  return 32'h0070_0000 | (32'(v) << 7) | 32'(f); endfunction
  function automatic logic [31:0] fCmd(int c);         return 32'h0060_0000 | 32'(c); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] w);
    @(negedge clk);
    progWe = 1'b1; progAddr = 8'(a); progData = w;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run();
    int cyc;
    cmdN = 0; xN = 0;
    pulseStart();
    cyc = 0;
    while (!done && !error && cyc < 2000) begin
      @(negedge clk); cyc++;
    end
  endtask

  // compare command log with up to three expected codes
  task automatic chkLog(string req, int n, int e0, int e1, int e2);
    int exp [3];
    bit ok;
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    ok = (cmdN == n);
    for (int i = 0; i < n && i < 3; i++) if (cmdLog[i] != exp[i]) ok = 1'b0;
    chk(ok, req, (cmdN << 12) | (cmdN > 0 ? cmdLog[0] << 8 : 0) | (cmdN > 1 ? cmdLog[1] << 4 : 0) | (cmdN > 2 ? cmdLog[2] : 0),
        (n << 12) | (e0 << 8) | (e1 << 4) | e2);
  endtask

  task automatic pulseReq(int f);
    @(negedge clk);
    case (f)
      5: userSaveReq = 1'b1;
      6: userLoadReq = 1'b1;
      100: autoSaveReq = 1'b1;
      default: autoLoadReq = 1'b1;
    endcase
    @(negedge clk);
    userSaveReq = 1'b0; userLoadReq = 1'b0; autoSaveReq = 1'b0; autoLoadReq = 1'b0;
  endtask

  initial begin
    int flags [4];
    int pend [4];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!running && !done && !error && !xferValid && !cmdStrobe && lenReg == 0, "R1 reset outputs",
        {running, done, error, xferValid, cmdStrobe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!running && lenReg == 0, "R1 idle after release", int'(running), 0);

    // R2 length load sweep
    for (int k = 0; k < 22; k++) begin
      int v;
      v = (k == 20) ? 'hFFFFF : (k == 21) ? 0 : ((k * 'h0B3A7 + 1) ^ (k << 15)) & 'hFFFFF;
      wr(0, fLen(v)); wr(1, fCmd('hE));
      run();
      chk(lenReg == 20'(v) && done, "R2 length load", int'(lenReg), v);
      chkLog("R8 end strobe after load", 1, 'hE, 0, 0);
    end

    // R4/R6 branch sweep over storage and constant flags
    flags[0] = 10; flags[1] = 37; flags[2] = 127; flags[3] = 104;
    for (int fi = 0; fi < 4; fi++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++) begin
          int fv;
          fv = (flags[fi] == 104) ? 1 : s;
          wr(0, fSet(flags[fi], s)); wr(1, fBra(flags[fi], p, 4));
          wr(2, fCmd(7)); wr(3, fCmd('hE)); wr(4, fCmd(9)); wr(5, fCmd('hE));
          run();
          chkLog(flags[fi] == 104 ? "R4 constant flag branch" : "R6 set then R4 branch",
                 2, (fv == p) ? 9 : 7, 'hE, 0);
        end

    // R4 jump to highest address
    wr(0, fBra(104, 1, 255)); wr(1, fCmd(7)); wr(2, fCmd('hE)); wr(255, fCmd('hE));
    run();
    chkLog("R4 jump to address 255", 1, 'hE, 0, 0);

    // R7 sticky request latches
    pend[0] = 5; pend[1] = 6; pend[2] = 100; pend[3] = 101;
    for (int fi = 0; fi < 4; fi++)
      for (int pl = 0; pl < 2; pl++) begin
        if (pl == 1) pulseReq(pend[fi]);
        wr(0, fSet(pend[fi], 1)); wr(1, fBra(pend[fi], 1, 4)); wr(2, fCmd(7)); wr(3, fCmd('hE));
        wr(4, fCmd(9)); wr(5, fSet(pend[fi], 0)); wr(6, fBra(pend[fi], 1, 9));
        wr(7, fCmd('hA)); wr(8, fCmd('hE)); wr(9, fCmd(7)); wr(10, fCmd('hE));
        run();
        if (pl == 1) chkLog("R7 latch set then cleared", 3, 9, 'hA, 'hE);
        else         chkLog("R7 set of 1 leaves latch clear", 2, 7, 'hE, 0);
      end

    // R7 live busy flag, R6 write to flag 96 ignored
    for (int b = 0; b < 2; b++) begin
      engBusy = 1'(b);
      wr(0, fSet(96, 1 - b)); wr(1, fBra(96, 1, 4)); wr(2, fCmd(7)); wr(3, fCmd('hE));
      wr(4, fCmd(9)); wr(5, fCmd('hE));
      run();
      chkLog("R7 busy flag reads input", 2, b ? 9 : 7, 'hE, 0);
    end

    // R5 wait stall, R10 start while running ignored
    engBusy = 1'b1;
    wr(0, fCmd('hA)); wr(1, fWait(96, 0)); wr(2, fCmd(9)); wr(3, fCmd('hE));
    cmdN = 0;
    pulseStart();
    repeat (8) @(negedge clk);
    chk(running && cmdN == 1, "R5 stalled on wait", cmdN, 1);
    pulseStart();
    repeat (3) @(negedge clk);
    engBusy = 1'b0;
    for (int c = 0; c < 50 && !done; c++) @(negedge clk);
    chkLog("R10 start while running ignored / R5 release", 3, 'hA, 9, 'hE);

    // R3 transfer sweep with acknowledge delays
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 8; k++) begin
        int r, c;
        r = (k == 7) ? 'h3FFF : (k * 1733 + d * 91) & 'h3FFF;
        c = (k == 7) ? 63 : (k * 9 + d * 5) % 64;
        ackDelay = d;
        wr(0, fXfer(r, c)); wr(1, fCmd(9)); wr(2, fCmd('hE));
        run();
        chk(xN == 1 && xRegLog == r && xCntLog == c, "R3 transfer fields",
            (xRegLog << 8) | xCntLog, (r << 8) | c);
        chkLog("R3 continues after ack", 2, 9, 'hE, 0);
      end
    ackDelay = 0;

    // R9 illegal words
    begin
      logic [31:0] bad [5];
      bad[0] = 32'h0030_0000; bad[1] = fCmd(8); bad[2] = fCmd('h17);
      bad[3] = 32'h0000_0000; bad[4] = 32'h0120_0005;
      for (int i = 0; i < 5; i++) begin
        wr(0, bad[i]); wr(1, fCmd('hE));
        run();
        chk(error && !done && cmdN == 0 && lenReg != 5, "R9 illegal word halts", {error, done}, 2);
      end
    end

    // R10 restart after error
    wr(0, fCmd('hE));
    run();
    chk(done && !error, "R10 restart clears error", {done, error}, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule